// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block decides which clock domains of a small 8-bit microcontroller keep running while the processor sleeps. Software picks a sleep mode with a 3-bit field and arms sleeping with an enable bit. A one-cycle sleep command then moves the block from the running state into sleep. While asleep, the block drives six domain enables according to the chosen mode: processor clock, I/O clock, memory clock, converter (ADC) clock, asynchronous timer clock and main oscillator.

Interrupt requests arrive grouped by class. A request wakes the block only if the logic that raises it still has a clock in the current mode. Three modes need a restart delay before clocks come back. The two modes that stop the oscillator wait for a programmable start-up count. The mode that keeps the oscillator running waits a short fixed delay. During that delay only the oscillator (and the asynchronous timer, if it was running) is enabled. Reset returns the block to the running state at once, with every enable high.

Top module: `slp_pwr_ctl`

## Requirements
- R1: While and after reset, with no sleep command, all six enables are 1 and `asleep` is 0.
- R2: A `sleep_cmd` pulse sampled with `sleep_en`=1 in the running state sets `asleep` to 1 on the next cycle. The enables then follow the selected mode.
- R3: A `sleep_cmd` sampled with `sleep_en`=0 is ignored: `asleep` stays 0 and all enables stay 1.
- R4: Mode code 000 (idle) turns off only the processor enable.
- R5: Mode code 001 (converter quiet) keeps the ADC, asynchronous timer and oscillator enables on and turns processor, I/O and memory off.
- R6: Mode code 010 (deep off) turns all six enables off.
- R7: Mode code 011 (timekeeping off) keeps only the asynchronous timer enable on.
- R8: Mode code 110 (warm standby) keeps only the oscillator enable on.
- R9: The unused codes 100, 101 and 111 behave exactly like idle.
- R10: `irq_req` bit 0 (external pin) always wakes. Bit 1 (asynchronous timer) wakes only if that timer's enable is on in the mode. Bit 2 (ADC) wakes only if the ADC enable is on. Bit 3 (synchronous I/O) wakes only if the I/O enable is on. A request that does not qualify leaves `asleep` at 1 and the enables unchanged.
- R11: Waking from idle, converter quiet or an unused code gives all enables 1 and `asleep` 0 on the cycle after the wake edge.
- R12: Waking from deep off or timekeeping off with `startup_cycles`=N>0 gives N start-up cycles. In those cycles the oscillator is on, the asynchronous timer enable keeps its sleep value, and the other four enables are off. After that, all enables are 1. N=0 wakes as in R11.
- R13: Waking from warm standby gives exactly 6 start-up cycles, with the same enable pattern as in R12.
- R14: Asserting `rst_n` low during sleep sets all enables to 1 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Sleep mode code |
| sleep_en | input | 1 | Arms the sleep command |
| sleep_cmd | input | 1 | One-cycle sleep request |
| irq_req | input | 4 | Interrupt requests by class: 0 external, 1 async timer, 2 ADC, 3 I/O |
| startup_cycles | input | CNT_W | Oscillator start-up count for the oscillator-off modes |
| en_cpu | output | 1 | Processor clock enable |
| en_io | output | 1 | I/O clock enable |
| en_mem | output | 1 | Memory clock enable |
| en_adc | output | 1 | Converter clock enable |
| en_rtc | output | 1 | Asynchronous timer clock enable |
| en_osc | output | 1 | Main oscillator enable |
| asleep | output | 1 | High in sleep and during start-up |

## Verification
A mode latched wrongly at sleep entry shows up on the enables in the first cycle after the sleep edge, because they come straight from the held mode. A wrong wake-qualification mask shows up within one cycle of a request: `asleep` either drops when it should not, or stays high when it should drop. A start-up counter that is off by any amount changes the number of cycles in which `asleep` stays high with the processor enable low. The bench counts those cycles exactly for every mode, every request class and two start-up values.

// File: rtl/slp_pkg.sv
package slp_pkg;

   localparam int NUM_IRQ = 4;
   localparam int IRQ_EXT = 0;
   localparam int IRQ_RTC = 1;
   localparam int IRQ_ADC = 2;
   localparam int IRQ_IO  = 3;

   typedef struct packed {
      logic cpu;
      logic io;
      logic mem;
      logic adc;
      logic rtc;
      logic osc;
   } dom_t;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_SLEEP = 2'd1,
      ST_START = 2'd2
   } pstate_e;

endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
   import slp_pkg::*;
(
   input  logic [2:0] code,
   output dom_t       dom,
   output logic       slow_restart,
   output logic       fast_restart
);

   always_comb begin
      slow_restart = 1'b0;
      fast_restart = 1'b0;
      unique case (code)
         3'b001:  dom = '{cpu:1'b0, io:1'b0, mem:1'b0, adc:1'b1, rtc:1'b1, osc:1'b1};
         3'b010: begin
            dom = '0;
            slow_restart = 1'b1;
         end
         3'b011: begin
            dom = '{cpu:1'b0, io:1'b0, mem:1'b0, adc:1'b0, rtc:1'b1, osc:1'b0};
            slow_restart = 1'b1;
         end
         3'b110: begin
            dom = '{cpu:1'b0, io:1'b0, mem:1'b0, adc:1'b0, rtc:1'b0, osc:1'b1};
            fast_restart = 1'b1;
         end
         default: dom = '{cpu:1'b0, io:1'b1, mem:1'b1, adc:1'b1, rtc:1'b1, osc:1'b1};
      endcase
   end

endmodule

// File: rtl/slp_wake_filter.sv
module slp_wake_filter
   import slp_pkg::*;
(
   input  logic [NUM_IRQ-1:0] irq,
   input  logic               rtc_on,
   input  logic               adc_on,
   input  logic               io_on,
   output logic               wake
);

   logic [NUM_IRQ-1:0] qual;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cls
      if (i == IRQ_EXT) begin : g_ext
         assign qual[i] = irq[i];
      end else if (i == IRQ_RTC) begin : g_rtc
         assign qual[i] = irq[i] & rtc_on;
      end else if (i == IRQ_ADC) begin : g_adc
         assign qual[i] = irq[i] & adc_on;
      end else begin : g_io
         assign qual[i] = irq[i] & io_on;
      end
   end

   assign wake = |qual;

endmodule

// File: rtl/slp_start_timer.sv
module slp_start_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   assert_cnt_down_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/slp_pwr_ctl.sv
module slp_pwr_ctl
   import slp_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int STBY_DELAY = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         mode_sel,
   input  logic               sleep_en,
   input  logic               sleep_cmd,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [CNT_W-1:0]   startup_cycles,
   output logic               en_cpu,
   output logic               en_io,
   output logic               en_mem,
   output logic               en_adc,
   output logic               en_rtc,
   output logic               en_osc,
   output logic               asleep
);

   localparam logic [CNT_W-1:0] STBY_M1 = CNT_W'(STBY_DELAY - 1);

   if (CNT_W < 3 || CNT_W > 24) begin : g_bad_width
      $error("slp_pwr_ctl: CNT_W out of range");
   end
   if (STBY_DELAY < 1 || STBY_DELAY >= (1 << CNT_W)) begin : g_bad_delay
      $error("slp_pwr_ctl: STBY_DELAY does not fit the counter");
   end

   pstate_e state;
   dom_t    dom_q, dec_dom, en;
   logic    slow_q, fast_q, dec_slow, dec_fast;
   logic    wake, need_start, tmr_load, tmr_done;
   logic [CNT_W-1:0] delay_m1;

   slp_mode_decode u_dec (
      .code         (mode_sel),
      .dom          (dec_dom),
      .slow_restart (dec_slow),
      .fast_restart (dec_fast)
   );

   slp_wake_filter u_wake (
      .irq    (irq_req),
      .rtc_on (dom_q.rtc),
      .adc_on (dom_q.adc),
      .io_on  (dom_q.io),
      .wake   (wake)
   );

   assign need_start = fast_q | (slow_q & (startup_cycles != '0));
   assign delay_m1   = fast_q ? STBY_M1 : (startup_cycles - 1'b1);
   assign tmr_load   = (state == ST_SLEEP) & wake & need_start;

   slp_start_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (delay_m1),
      .done     (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_RUN;
         dom_q  <= '1;
         slow_q <= 1'b0;
         fast_q <= 1'b0;
      end else begin
         unique case (state)
            ST_RUN: if (sleep_cmd && sleep_en) begin
               state  <= ST_SLEEP;
               dom_q  <= dec_dom;
               slow_q <= dec_slow;
               fast_q <= dec_fast;
            end
            ST_SLEEP: if (wake) state <= need_start ? ST_START : ST_RUN;
            ST_START: if (tmr_done) state <= ST_RUN;
            default:  state <= ST_RUN;
         endcase
      end
   end

   always_comb begin
      unique case (state)
         ST_SLEEP: en = dom_q;
         ST_START: en = '{cpu:1'b0, io:1'b0, mem:1'b0, adc:1'b0, rtc:dom_q.rtc, osc:1'b1};
         default:  en = '1;
      endcase
   end

   assign en_cpu = en.cpu;
   assign en_io  = en.io;
   assign en_mem = en.mem;
   assign en_adc = en.adc;
   assign en_rtc = en.rtc;
   assign en_osc = en.osc;
   assign asleep = (state != ST_RUN);

   assert_sleep_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && sleep_cmd && !sleep_en) |=> !asleep);

   assert_cpu_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> !en_cpu);

   assert_deep_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SLEEP && slow_q && !dom_q.rtc) |->
      !(en_cpu | en_io | en_mem | en_adc | en_rtc | en_osc));

   assert_no_false_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SLEEP && !wake) |=> (state == ST_SLEEP));

   assert_start_osc_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START) |-> (en_osc && !en_io && !en_mem && !en_adc));

   assert_reset_on_R14: assert property (@(posedge clk)
      !rst_n |-> (en_cpu && en_io && en_mem && en_adc && en_rtc && en_osc && !asleep));

endmodule

// File: tb/slp_pwr_ctl_tb.sv
module slp_pwr_ctl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode_sel = '0;
   logic       sleep_en = 1'b0;
   logic       sleep_cmd = 1'b0;
   logic [3:0] irq_req = '0;
   logic [7:0] startup_cycles = '0;
   logic en_cpu, en_io, en_mem, en_adc, en_rtc, en_osc, asleep;

   int checks = 0;
   int errs = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   slp_pwr_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_en(sleep_en),
      .sleep_cmd(sleep_cmd), .irq_req(irq_req), .startup_cycles(startup_cycles),
      .en_cpu(en_cpu), .en_io(en_io), .en_mem(en_mem), .en_adc(en_adc),
      .en_rtc(en_rtc), .en_osc(en_osc), .asleep(asleep)
   );

   function automatic logic [5:0] mask();
      return {en_cpu, en_io, en_mem, en_adc, en_rtc, en_osc};
   endfunction

   // order: cpu io mem adc rtc osc
   function automatic logic [5:0] exp_dom(int code);
      case (code)
         1:       return 6'b000111;
         2:       return 6'b000000;
         3:       return 6'b000010;
         6:       return 6'b000001;
         default: return 6'b011111;
      endcase
   endfunction

   function automatic string mode_req(int code);
      case (code)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         3: return "R7";
         6: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick();
      chk("R1", {26'd0, mask()}, 32'h3F);
      chk("R1", {31'd0, asleep}, 32'd0);
      rst_n = 1'b1;
      tick();
   endtask

   initial begin
      #(5.0 * 150000);
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
   end

   initial begin
      tick();
      do_reset();

      // R3: command without arm is ignored
      mode_sel = 3'b010; sleep_en = 1'b0; sleep_cmd = 1'b1;
      tick();
      sleep_cmd = 1'b0;
      chk("R3", {31'd0, asleep}, 32'd0);
      chk("R3", {26'd0, mask()}, 32'h3F);

      for (int code = 0; code < 8; code++) begin
         for (int b = 0; b < 4; b++) begin
            for (int si = 0; si < 2; si++) begin
               logic [5:0] ed;
               bit valid;
               int exp_k;
               int k;
               ed = exp_dom(code);
               do_reset();
               startup_cycles = (si == 0) ? 8'd0 : 8'd3;
               mode_sel = code[2:0]; sleep_en = 1'b1; sleep_cmd = 1'b1;
               tick();
               sleep_cmd = 1'b0;
               chk("R2", {31'd0, asleep}, 32'd1);
               chk(mode_req(code), {26'd0, mask()}, {26'd0, ed});

               case (b)
                  0: valid = 1'b1;
                  1: valid = ed[1];
                  2: valid = ed[2];
                  default: valid = ed[4];
               endcase
               irq_req = 4'(1 << b);
               tick();
               irq_req = '0;
               if (!valid) begin
                  chk("R10", {31'd0, asleep}, 32'd1);
                  chk("R10", {26'd0, mask()}, {26'd0, ed});
                  irq_req = 4'b0001;
                  tick();
                  irq_req = '0;
               end

               if (code == 2 || code == 3) exp_k = int'(startup_cycles);
               else if (code == 6)         exp_k = 6;
               else                        exp_k = 0;

               k = 0;
               while (asleep && k < 40) begin
                  chk((code == 6) ? "R13" : "R12", {26'd0, mask()},
                      {26'd0, 4'b0000, ed[1], 1'b1});
                  k++;
                  tick();
               end
               chk((code == 6) ? "R13" : ((code == 2 || code == 3) ? "R12" : "R11"),
                   k, exp_k);
               chk("R11", {26'd0, mask()}, 32'h3F);
            end
         end
      end

      // R14: reset during deep sleep takes effect without a clock edge
      mode_sel = 3'b010; sleep_en = 1'b1; sleep_cmd = 1'b1;
      tick();
      sleep_cmd = 1'b0;
      chk("R6", {26'd0, mask()}, 32'h00);
      #1 rst_n = 1'b0;
      #0.5;
      chk("R14", {26'd0, mask()}, 32'h3F);
      chk("R14", {31'd0, asleep}, 32'd0);
      tick();
      rst_n = 1'b1;
      tick();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule